// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block divides its input clock by an average ratio that need not be an integer. A core counter divides by 10 or by 11, depending on a select driven by a small sequencer. A frame consists of a low phase and a high phase. The low phase lasts a programmed number of output periods at divide-by-10. The high phase lasts a second programmed number of output periods at divide-by-11. Frames follow one another with no gap. Over one frame, with A low-phase periods and B high-phase periods, the block delivers A+B output pulses in 10·A+11·B input cycles.

The output period jumps between 10 and 11 input periods at each phase boundary, with no smoothing. A frame-start flag marks the first pulse of every frame, so an observer can measure frame length and average ratio. The two period counts are latched when a frame begins. A change made mid-frame therefore applies only from the next frame onward. Dropping the enable returns the block to an idle, cleared state.

Top module: `fdiv_dual_mod`

## Requirements
- R1: While the low phase is active, consecutive output pulses are exactly 10 input cycles apart. While the high phase is active, they are exactly 11 input cycles apart.
- R2: The divided output `div_pulse_o` is high for exactly one input clock cycle per output period. After enable rises, the first pulse falls in the 10th enabled cycle when the low count is nonzero, and in the 11th enabled cycle when the low count is zero.
- R3: Each frame produces `cnt_lo_i` pulses at period 10, then `cnt_hi_i` pulses at period 11. The pattern then repeats.
- R4: `frame_start_o` is high together with the first pulse of every frame and at no other time, so one frame spans 10·A+11·B input cycles.
- R5: While enabled, the count inputs are sampled only in the cycle of a frame's last pulse. A change applied mid-frame leaves the current frame unchanged and governs every frame after it.
- R6: When the low count is zero, every output period is 11 cycles. When the high count is zero, every output period is 10 cycles.
- R7: When both counts are zero, `div_pulse_o` and `frame_start_o` stay low.
- R8: While `en` is low, both outputs are low and every counter is cleared. On re-enable, the sequence restarts from the first pulse of a new frame.
- R9: While `rst_n` is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears and holds the divider |
| cnt_lo_i | input | CW (8) | Output periods per frame at divide-by-10 |
| cnt_hi_i | input | CW (8) | Output periods per frame at divide-by-11 |
| div_pulse_o | output | 1 | One-cycle divided clock pulse |
| frame_start_o | output | 1 | High with the first pulse of each frame |

## Verification
Suppose the core counter terminates on the wrong value or uses a stale select. The next output pulse then lands one cycle early or late, which shows at the ports within 11 cycles. Suppose the phase counter or sequencer is off by one. The pulse that should open the 11-cycle periods, or the frame-start flag, then moves by a whole period, which becomes visible within one frame of 10·A+11·B cycles. A latch that captures settings at the wrong moment only shows when the frame after the change has the wrong shape. For that reason the settings are changed mid-frame and at least two frames are observed afterwards.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  typedef enum logic [1:0] {
    PH_OFF = 2'd0,
    PH_LO  = 2'd1,
    PH_HI  = 2'd2
  } phase_e;

  // Phase a new frame opens with, given which counts are nonzero.
  function automatic phase_e first_phase(input logic lo_nz, input logic hi_nz);
    if (lo_nz) return PH_LO;
    else if (hi_nz) return PH_HI;
    else return PH_OFF;
  endfunction

  // Terminal count of the core counter for the selected modulus.
  function automatic int unsigned terminal_count(input logic mod_hi, input int unsigned mod_lo);
    return mod_hi ? mod_lo : mod_lo - 1;
  endfunction

  // Input cycles spanned by one frame.
  function automatic int unsigned frame_span(input int unsigned n_lo, input int unsigned n_hi,
                                             input int unsigned mod_lo);
    return n_lo * mod_lo + n_hi * (mod_lo + 1);
  endfunction

endpackage

// File: rtl/fdiv_prescaler.sv
module fdiv_prescaler #(
  parameter int unsigned MOD_LO = 10,
  parameter int unsigned PW     = $clog2(MOD_LO + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          mod_hi,
  output logic [PW-1:0] cnt_o,
  output logic          wrap_o
);
  import fdiv_pkg::*;

  logic [PW-1:0] last;
  assign last   = PW'(terminal_count(mod_hi, MOD_LO));
  assign wrap_o = run && (cnt_o == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (!run)   cnt_o <= '0;
    else if (wrap_o) cnt_o <= '0;
    else             cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/fdiv_phase_cnt.sv
module fdiv_phase_cnt #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt_o,
  output logic          done_o
);
  assign done_o = step && (cnt_o == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (!run)   cnt_o <= '0;
    else if (done_o) cnt_o <= '0;
    else if (step)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl #(
  parameter int unsigned CW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CW-1:0]    set_lo,
  input  logic [CW-1:0]    set_hi,
  input  logic             wrap,
  input  logic             done,
  output fdiv_pkg::phase_e phase_o,
  output logic             mod_hi_o,
  output logic             run_o,
  output logic [CW-1:0]    limit_o,
  output logic             first_o,
  output logic             load_o,
  output logic [CW-1:0]    lo_q,
  output logic [CW-1:0]    hi_q
);
  import fdiv_pkg::*;

  logic frame_end;
  assign frame_end = done && ((phase_o == PH_HI) || (hi_q == '0));
  assign load_o    = !en || (phase_o == PH_OFF) || frame_end;
  assign run_o     = en && (phase_o != PH_OFF);
  assign mod_hi_o  = (phase_o == PH_HI);
  assign limit_o   = mod_hi_o ? hi_q : lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o <= PH_OFF;
      lo_q    <= '0;
      hi_q    <= '0;
      first_o <= 1'b1;
    end else if (load_o) begin
      phase_o <= first_phase(|set_lo, |set_hi);
      lo_q    <= set_lo;
      hi_q    <= set_hi;
      first_o <= 1'b1;
    end else begin
      if (done) phase_o <= PH_HI;
      if (wrap) first_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fdiv_dual_mod.sv
module fdiv_dual_mod #(
  parameter int unsigned MOD_LO = 10,
  parameter int unsigned CW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] cnt_lo_i,
  input  logic [CW-1:0] cnt_hi_i,
  output logic          div_pulse_o,
  output logic          frame_start_o
);
  import fdiv_pkg::*;

  localparam int unsigned PW = $clog2(MOD_LO + 1);

  phase_e        phase;
  logic          mod_hi;
  logic          run;
  logic          wrap;
  logic          done;
  logic          first;
  logic          load;
  logic [CW-1:0] limit;
  logic [CW-1:0] lo_q;
  logic [CW-1:0] hi_q;
  logic [PW-1:0] pre_cnt;
  logic [CW-1:0] sel_cnt;

  fdiv_prescaler #(.MOD_LO(MOD_LO), .PW(PW)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .mod_hi(mod_hi),
    .cnt_o(pre_cnt), .wrap_o(wrap)
  );

  fdiv_phase_cnt #(.CW(CW)) u_sel (
    .clk(clk), .rst_n(rst_n), .run(run), .step(wrap), .limit(limit),
    .cnt_o(sel_cnt), .done_o(done)
  );

  fdiv_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .set_lo(cnt_lo_i), .set_hi(cnt_hi_i),
    .wrap(wrap), .done(done), .phase_o(phase), .mod_hi_o(mod_hi),
    .run_o(run), .limit_o(limit), .first_o(first), .load_o(load),
    .lo_q(lo_q), .hi_q(hi_q)
  );

  assign div_pulse_o   = wrap;
  assign frame_start_o = wrap && first;
endmodule

// File: rtl/fdiv_dual_mod_chk.sv
module fdiv_dual_mod_chk #(
  parameter int unsigned MOD_LO = 10,
  parameter int unsigned CW     = 8,
  parameter int unsigned PW     = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          pulse,
  input logic          fstart,
  input logic          mod_hi,
  input logic          run,
  input logic          load,
  input logic [PW-1:0] pre_cnt,
  input logic [CW-1:0] sel_cnt,
  input logic [CW-1:0] limit,
  input logic [CW-1:0] lo_q,
  input logic [CW-1:0] hi_q
);
  localparam int unsigned GW = PW + 1;
  localparam logic [GW-1:0] GAP_LO = GW'(MOD_LO);
  localparam logic [GW-1:0] GAP_HI = GW'(MOD_LO + 1);

  logic [GW-1:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap <= 1;
    else if (!run)       gap <= 1;
    else if (pulse)      gap <= 1;
    else if (gap != '1)  gap <= gap + 1'b1;
  end

  p_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (gap == (mod_hi ? GAP_HI : GAP_LO)));

  p_frame_on_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fstart |-> pulse);

  p_sel_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (sel_cnt < limit));

  p_hold_settings_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> ($stable(lo_q) && $stable(hi_q)));

  p_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((lo_q == '0) && (hi_q == '0)) |-> !pulse);

  p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((pre_cnt == '0) && (sel_cnt == '0)));

  always_comb begin
    if (rst_n === 1'b0) p_reset_quiet_r9: assert (!pulse && !fstart);
  end
endmodule

bind fdiv_dual_mod fdiv_dual_mod_chk #(.MOD_LO(MOD_LO), .CW(CW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pulse(div_pulse_o), .fstart(frame_start_o),
  .mod_hi(mod_hi), .run(run), .load(load), .pre_cnt(pre_cnt), .sel_cnt(sel_cnt),
  .limit(limit), .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/fdiv_dual_mod_tb.sv
module fdiv_dual_mod_tb;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [CW-1:0] cnt_lo_i = '0;
  logic [CW-1:0] cnt_hi_i = '0;
  logic          div_pulse_o;
  logic          frame_start_o;

  int checks = 0;
  int failures = 0;
  bit reported = 0;

  int q_t[$];
  bit q_f[$];
  int ecnt = 0;

  always #10ns clk = ~clk;

  fdiv_dual_mod u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cnt_lo_i(cnt_lo_i), .cnt_hi_i(cnt_hi_i),
    .div_pulse_o(div_pulse_o), .frame_start_o(frame_start_o)
  );

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: pops the expected pulse schedule as the design produces pulses.
  always @(negedge clk) begin
    if (rst_n) begin
      if (!en) begin
        ecnt = 0;
        checks++;
        if (div_pulse_o || frame_start_o) begin
          failures++;
          $display("FAIL R8 disabled outputs pulse=%0b fs=%0b expected 0 0",
                   div_pulse_o, frame_start_o);
        end
      end else begin
        ecnt++;
        if (div_pulse_o) begin
          checks++;
          if (q_t.size() == 0 || q_t[0] != ecnt) begin
            failures++;
            $display("FAIL R1/R2 unexpected pulse at enabled cycle %0d expected next at %0d",
                     ecnt, (q_t.size() == 0) ? -1 : q_t[0]);
          end else begin
            checks++;
            if (frame_start_o != q_f[0]) begin
              failures++;
              $display("FAIL R4 frame flag at cycle %0d actual %0b expected %0b",
                       ecnt, frame_start_o, q_f[0]);
            end
            void'(q_t.pop_front());
            void'(q_f.pop_front());
          end
        end else begin
          if (frame_start_o) begin
            checks++; failures++;
            $display("FAIL R4 flag without pulse at cycle %0d actual 1 expected 0", ecnt);
          end
          if (q_t.size() != 0 && q_t[0] == ecnt) begin
            checks++; failures++;
            $display("FAIL R3 missing pulse at cycle %0d actual 0 expected 1", ecnt);
            void'(q_t.pop_front());
            void'(q_f.pop_front());
          end
        end
      end
    end
  end

  // Driver: builds the expected schedule from the requirements, then drives.
  task automatic run_case(input int a, input int b, input int n,
                          input int c, input int a2, input int b2);
    int t = 0;
    int ca = a;
    int cb = b;
    while (t < n && (ca != 0 || cb != 0)) begin
      for (int i = 0; i < ca; i++) begin
        t += 10;
        if (t <= n) begin q_t.push_back(t); q_f.push_back(i == 0); end
      end
      for (int j = 0; j < cb; j++) begin
        t += 11;
        if (t <= n) begin q_t.push_back(t); q_f.push_back(ca == 0 && j == 0); end
      end
      if (c != 0 && c <= t) begin ca = a2; cb = b2; end
    end
    @(posedge clk); #1ns;
    en = 1'b0; cnt_lo_i = CW'(a); cnt_hi_i = CW'(b);
    repeat (2) @(posedge clk);
    #1ns en = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (k == c) begin #1ns cnt_lo_i = CW'(a2); cnt_hi_i = CW'(b2); end
    end
    @(posedge clk); #1ns en = 1'b0;
    @(negedge clk);
    checks++;
    if (q_t.size() != 0) begin
      failures++;
      $display("FAIL R3 %0d expected pulses not seen, actual %0d expected 0", q_t.size(), q_t.size());
      q_t.delete(); q_f.delete();
    end
  endtask

  initial begin
    cnt_lo_i = 8'd3; cnt_hi_i = 8'd2; en = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (div_pulse_o || frame_start_o) begin  // R9
      failures++;
      $display("FAIL R9 outputs in reset pulse=%0b fs=%0b expected 0 0", div_pulse_o, frame_start_o);
    end
    repeat (12) @(negedge clk);
    checks++;
    if (div_pulse_o || frame_start_o) begin  // R9 held across a full period
      failures++;
      $display("FAIL R9 outputs in reset pulse=%0b fs=%0b expected 0 0", div_pulse_o, frame_start_o);
    end
    en = 1'b0;
    @(posedge clk); #1ns rst_n = 1'b1;
    run_case(3, 2, 200, 0, 0, 0);    // R1 R3 R4, ends mid-frame
    run_case(3, 2, 60, 0, 0, 0);     // R8 restart after mid-frame disable
    run_case(0, 4, 120, 0, 0, 0);    // R6 low count zero
    run_case(5, 0, 120, 0, 0, 0);    // R6 high count zero
    run_case(0, 0, 100, 0, 0, 0);    // R7 both zero
    run_case(1, 1, 100, 0, 0, 0);    // R2 R4 shortest frame
    run_case(2, 3, 250, 30, 4, 1);   // R5 mid-frame change
    run_case(6, 0, 200, 25, 1, 3);   // R5 change inside an all-10 stream
    report();
  end

  initial begin
    #3ms;
    failures++;
    $display("FAIL watchdog run did not complete actual timeout expected finish");
    report();
  end
endmodule